// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter built from 4-bit stages. Each stage has a parallel load, two count enables with different roles, and a terminal-count carry. The top module chains a parameterised number of stages into one wide counter. The carry of each stage drives the chain enable of the stage above it, so no extra gating is needed between stages. Every state bit in every stage changes on the same rising clock edge.

An active-low clear forces the whole counter to zero as soon as it is asserted, without waiting for a clock edge. At a rising edge the priority is clear, then load, then count, then hold.

The two enables are not equal. `en_count` is a plain permission to count. `en_chain` also gates the carry output, and that feed-forward is what makes lookahead cascading work. A host that loads a value or suspends counting therefore still sees a valid terminal-count signal on `carry_out`.

Top module: `casc_counter`

## Requirements
- R1: While `clear_n` is low, `count_out` is zero. The clear acts at once, with no clock edge needed.
- R2: With `clear_n` high and `load_n` low at a rising edge, `count_out` takes the value of `data_in` after that edge.
- R3: A load takes effect whatever the levels of `en_count` and `en_chain`, including when both are high.
- R4: With `clear_n` and `load_n` high and both enables high at a rising edge, the full chained value in `count_out` rises by exactly one. Carries pass between the 4-bit stages within that same edge.
- R5: With `clear_n` and `load_n` high and either enable low at a rising edge, `count_out` keeps its value.
- R6: `carry_out` is high exactly when `en_chain` is high and every bit of `count_out` is one. It follows its inputs combinationally, with no clock delay.
- R7: `carry_out` does not depend on `en_count`. With the count at all ones and `en_chain` high, `carry_out` is high even while `en_count` is low.
- R8: Counting up from all ones wraps the whole chained value to zero, and `carry_out` falls with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all stages |
| clear_n | input | 1 | Active-low direct clear, asynchronous |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_count | input | 1 | Count permission, shared by all stages |
| en_chain | input | 1 | Chain enable of the lowest stage; also gates the carry |
| data_in | input | STAGES*STAGE_W | Parallel load value, lowest stage in the low bits |
| count_out | output | STAGES*STAGE_W | Chained counter value |
| carry_out | output | 1 | Terminal-count carry of the highest stage |

## Verification
The assertions assume that every control input is at a defined level at each rising edge while `clear_n` is high. They also assume that `clear_n` is released away from a clock edge, so the cycle after release starts from a known zero. The bench meets both conditions. It drives every input on the falling edge. It sets all controls before it releases the clear. It asserts the asynchronous clear only in the middle of a low clock phase. Enable and load patterns come from a pseudo-random sequence, so the carries between stages are exercised at many different values.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int STAGE_W = 4;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } cnt_op_e;

    // Load outranks both enables; counting needs both enables.
    function automatic cnt_op_e pick_op(input logic load_n,
                                        input logic en_count,
                                        input logic en_chain);
        if (!load_n)
            return OP_LOAD;
        else if (en_count && en_chain)
            return OP_COUNT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/cnt_next.sv
module cnt_next
    import cnt_pkg::*;
#(
    parameter int W = STAGE_W
) (
    input  cnt_op_e      op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] data,
    output logic [W-1:0] nxt
);

    always_comb begin
        unique case (op)
            OP_LOAD:  nxt = data;
            OP_COUNT: nxt = cur + 1'b1;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
    parameter int W = 4
) (
    input  logic [W-1:0] value,
    input  logic         en_chain,
    output logic         carry
);

    // Terminal count is gated only by the chain enable.
    assign carry = en_chain & (&value);

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int W = STAGE_W
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic         en_count,
    input  logic         en_chain,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] value_o,
    output logic         carry_o
);

    typedef struct packed {
        logic [W-1:0] value;
    } stage_reg_t;

    stage_reg_t   state_d, state_q;
    cnt_op_e      op_d;
    logic [W-1:0] nxt_value;

    cnt_next #(.W(W)) u_next (
        .op   (op_d),
        .cur  (state_q.value),
        .data (data_in),
        .nxt  (nxt_value)
    );

    always_comb begin
        op_d          = pick_op(load_n, en_count, en_chain);
        state_d       = state_q;
        state_d.value = nxt_value;
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    cnt_tc #(.W(W)) u_tc (
        .value    (state_q.value),
        .en_chain (en_chain),
        .carry    (carry_o)
    );

    assign value_o = state_q.value;

endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import cnt_pkg::*;
#(
    parameter int STAGES = 3,
    parameter int SW     = STAGE_W
) (
    input  logic                 clk,
    input  logic                 clear_n,
    input  logic                 load_n,
    input  logic                 en_count,
    input  logic                 en_chain,
    input  logic [STAGES*SW-1:0] data_in,
    output logic [STAGES*SW-1:0] count_out,
    output logic                 carry_out
);

    localparam int TOTAL_W = STAGES * SW;

    // chain_q[i] is the chain enable of stage i; chain_q[STAGES] is the top carry.
    logic [STAGES:0] chain_q;

    assign chain_q[0] = en_chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        cnt_stage #(.W(SW)) u_stage (
            .clk      (clk),
            .clear_n  (clear_n),
            .load_n   (load_n),
            .en_count (en_count),
            .en_chain (chain_q[g]),
            .data_in  (data_in[g*SW +: SW]),
            .value_o  (count_out[g*SW +: SW]),
            .carry_o  (chain_q[g+1])
        );
    end

    assign carry_out = chain_q[STAGES];

    logic unused_width;
    assign unused_width = (TOTAL_W == 0);

endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
    parameter int STAGES = 3,
    parameter int SW     = 4
) (
    input logic                 clk,
    input logic                 clear_n,
    input logic                 load_n,
    input logic                 en_count,
    input logic                 en_chain,
    input logic [STAGES*SW-1:0] data_in,
    input logic [STAGES*SW-1:0] count_out,
    input logic                 carry_out
);

    p_clear_zero_r1: assert property (@(posedge clk)
        !clear_n |-> (count_out == '0));

    p_load_copy_r2: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> (count_out == $past(data_in)));

    p_load_prio_r3: assert property (@(posedge clk) disable iff (!clear_n)
        (!load_n && en_count && en_chain) |=> (count_out == $past(data_in)));

    p_count_step_r4: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && en_count && en_chain) |=> (count_out == $past(count_out) + 1'b1));

    p_hold_r5: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(en_count && en_chain)) |=> $stable(count_out));

    p_carry_tc_r6: assert property (@(posedge clk) disable iff (!clear_n)
        carry_out == (en_chain && (&count_out)));

    p_carry_no_enp_r7: assert property (@(posedge clk) disable iff (!clear_n)
        (!en_count && en_chain && (&count_out)) |-> carry_out);

    p_wrap_r8: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && en_count && en_chain && (&count_out)) |=> (count_out == '0));

endmodule

bind casc_counter casc_counter_chk #(.STAGES(STAGES), .SW(SW)) u_chk (
    .clk       (clk),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .en_count  (en_count),
    .en_chain  (en_chain),
    .data_in   (data_in),
    .count_out (count_out),
    .carry_out (carry_out)
);

// File: tb/casc_counter_tb.sv
module casc_counter_tb;

    localparam int STAGES = 3;
    localparam int SW     = 4;
    localparam int TW     = STAGES * SW;

    logic          clk      = 1'b0;
    logic          clear_n  = 1'b1;
    logic          load_n   = 1'b1;
    logic          en_count = 1'b0;
    logic          en_chain = 1'b0;
    logic [TW-1:0] data_in  = '0;
    logic [TW-1:0] count_out;
    logic          carry_out;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [TW-1:0] cnt;
        logic          cy;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [TW-1:0] model = '0;

    always #4 clk = ~clk;

    casc_counter #(.STAGES(STAGES), .SW(SW)) u_dut (
        .clk       (clk),
        .clear_n   (clear_n),
        .load_n    (load_n),
        .en_count  (en_count),
        .en_chain  (en_chain),
        .data_in   (data_in),
        .count_out (count_out),
        .carry_out (carry_out)
    );

    task automatic check(input string tag, input logic [TW-1:0] act_c, input logic act_k,
                         input logic [TW-1:0] exp_c, input logic exp_k);
        checks++;
        if (act_c !== exp_c || act_k !== exp_k) begin
            errors++;
            $display("FAIL %s: count=%h carry=%b expected count=%h carry=%b",
                     tag, act_c, act_k, exp_c, exp_k);
        end
    endtask

    // Driver: sets inputs at the falling edge and predicts the state after the next rising edge.
    task automatic step(input logic clr, input logic ld, input logic ep, input logic et,
                        input logic [TW-1:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        clear_n  = clr;
        load_n   = ld;
        en_count = ep;
        en_chain = et;
        data_in  = d;
        if (!clr)          model = '0;
        else if (!ld)      model = d;
        else if (ep && et) model = model + 1'b1;
        e.cnt = model;
        e.cy  = et && (&model);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, count_out, carry_out, e.cnt, e.cy);
            end
        end
    end

    initial begin
        #1 clear_n = 1'b0;
        #1 check("R1 reset", count_out, carry_out, '0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b1, 12'h5A5, "R1 clear held");
        step(1'b0, 1'b1, 1'b1, 1'b1, 12'h000, "R1 clear held");
        // R2: load with enables low.
        step(1'b1, 1'b0, 1'b0, 1'b0, 12'hABC, "R2 load");
        // R3: load wins over both enables.
        step(1'b1, 1'b0, 1'b1, 1'b1, 12'h123, "R3 load priority");
        step(1'b1, 1'b0, 1'b0, 1'b1, 12'h3C7, "R3 load enp low");
        // R4: counting.
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R4 count");
        // R5: hold with either enable low.
        step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R5 hold enp");
        step(1'b1, 1'b1, 1'b1, 1'b0, 12'h000, "R5 hold ent");
        step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R5 hold both");
        // R4: carry between stages.
        step(1'b1, 1'b0, 1'b0, 1'b0, 12'h0FE, "R2 load");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R4 stage carry");
        // R6 and R8: terminal count and wrap.
        step(1'b1, 1'b0, 1'b0, 1'b1, 12'hFFE, "R2 load");
        step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R6 carry at all ones");
        step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, "R8 wrap");
        // R7: carry ignores en_count, follows en_chain.
        step(1'b1, 1'b0, 1'b0, 1'b1, 12'hFFF, "R2 load");
        step(1'b1, 1'b1, 1'b0, 1'b1, 12'h000, "R7 carry enp low");
        step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, "R6 carry ent low");
        @(negedge clk);
        en_chain = 1'b1;
        #1 check("R6 combinational carry", count_out, carry_out, 12'hFFF, 1'b1);
        // R1: clear mid-cycle acts without a clock edge.
        @(negedge clk);
        #1 clear_n = 1'b0;
        #1 check("R1 async clear", count_out, carry_out, '0, 1'b0);
        model = '0;
        step(1'b0, 1'b1, 1'b1, 1'b1, 12'h000, "R1 clear held");
        // Pseudo-random control toggling.
        begin
            logic [31:0] lcg = 32'h1ACE_0F17;
            for (int i = 0; i < 300; i++) begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                step(1'b1, (lcg[27:24] != 4'h0), lcg[30] | lcg[29], lcg[31] | lcg[28],
                     lcg[19:8], "R4 random mix");
            end
        end
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: count=%h carry=%b expected finish", count_out, carry_out);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule